// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block keeps a table of transmit descriptors, each a 32-bit status/control word paired with a 32-bit buffer address. Software fills the table through a simple register bus. The engine walks the table in ring order. When it finds a descriptor that software has handed over, it presents that frame's length, buffer address and per-frame options on a frame-transmit handshake. It then waits for a completion report. The report stands in for the data fetch, the serialiser and the checksum logic, which sit outside this block.

When a frame completes, the engine returns ownership of the descriptor to software. It does this by clearing the ownership bit and writing the result flags into the low bits of the same status word. If the descriptor asked for an interrupt, the engine also latches a success or error interrupt source. The number of active descriptors is programmable. A per-descriptor wrap flag, or the end of the active count, sends the engine back to entry 0.

Top module: `txr_engine`

## Requirements
- R1: After reset, frmValid and irqPending are 0, and reads of the count register, the interrupt register and every descriptor word return 0.
- R2: The count register is at byte address 0x000 and the interrupt register at 0x004. Descriptor i has its status word at 0x400 + 8*i and its buffer address at 0x404 + 8*i. A read returns the last value written.
- R3: A count write above 128 stores 128; any other value is stored as written.
- R4: When the descriptor at the current index has ready (bit 15) set and the index is below the count, frmValid rises. frmLen then shows status bits 31:16, frmAddr the address word, frmPad bit 12 and frmCrc bit 11. The offer holds until frmReady is seen.
- R5: If the descriptor at the current index has ready clear, the engine waits at that index. It offers no other descriptor, even one that is ready.
- R6: When doneValid arrives, the status word gets bit 15 cleared and bits 8:0 replaced by doneResult. In doneResult, bit 0 is carrier lost, bit 1 deferred, bit 2 late collision, bit 3 retry limit, bits 7:4 retry count and bit 8 underrun. Bits 31:16 and 14:9 keep their current value.
- R7: After a completion, the index returns to 0 if the descriptor had wrap (bit 13) set, or if index+1 equals the count. Otherwise the index increments.
- R8: A completion whose descriptor has bit 14 set raises interrupt source bit 1 if late collision, retry limit, underrun or carrier lost is reported, and source bit 0 otherwise. With bit 14 clear, the sources do not change. irqPending is the OR of the two sources.
- R9: Reading 0x004 returns the sources in bits 1:0. Writing 1 to a bit there clears that source and leaves the other one unchanged.
- R10: Bus writes to a descriptor after it has been offered are stored, but frmLen and frmAddr keep the offered values until the completion.
- R11: With the count at 0, nothing is offered. If the count is lowered to or below the current index, the engine restarts at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| frmValid | output | 1 | Frame offered |
| frmReady | input | 1 | Frame accepted |
| frmLen | output | 16 | Offered frame length |
| frmAddr | output | 32 | Offered buffer address |
| frmPad | output | 1 | Offered pad request |
| frmCrc | output | 1 | Offered checksum request |
| doneValid | input | 1 | Completion report strobe |
| doneResult | input | 9 | Completion result flags |
| irqPending | output | 1 | Any interrupt source set |

## Verification
The hardest case to reach from the ports is the ownership wait. A later descriptor is ready while the current one is not, and the engine must stay put. The stimulus prepares descriptors out of order, watches the offer line for a long quiet window, and only then hands over the blocking entry. A second difficult case is a rewrite of a descriptor while its frame is in flight. The bench accepts the offer, holds back the completion, and rewrites both words meanwhile, so the latched frame fields and the merged write-back can both be compared.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int ST_READY = 15;
  localparam int ST_IE    = 14;
  localparam int ST_WRAP  = 13;
  localparam int ST_PAD   = 12;
  localparam int ST_CRC   = 11;
  localparam int RES_W    = 9;

  typedef struct packed {
    logic load;
    logic writeBack;
  } txStrobe_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_OFFER = 2'd1,
    S_WAIT  = 2'd2
  } txState_t;

  function automatic logic isTxError(input logic [RES_W-1:0] res);
    return res[0] | res[2] | res[3] | res[8];
  endfunction
endpackage

// File: rtl/txr_datapath.sv
module txr_datapath
  import txr_pkg::*;
#(
  parameter int MAX_DESC  = 128,
  parameter int ADDR_W    = 12,
  parameter int DESC_BASE = 'h400,
  localparam int IDX_W = $clog2(MAX_DESC),
  localparam int CNT_W = $clog2(MAX_DESC + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  txStrobe_t         stb,
  input  logic [IDX_W-1:0]  curIdx,
  input  logic [RES_W-1:0]  doneResult,
  output logic              curReady,
  output logic              frmWrap,
  output logic [CNT_W-1:0]  descCount,
  output logic [15:0]       frmLen,
  output logic [31:0]       frmAddr,
  output logic              frmPad,
  output logic              frmCrc,
  output logic              irqPending
);
  localparam int DESC_END = DESC_BASE + 8 * MAX_DESC;
  localparam logic [ADDR_W-1:0] CNT_OFF = '0;
  localparam logic [ADDR_W-1:0] IRQ_OFF = ADDR_W'(4);

  logic [31:0] statMem [MAX_DESC];
  logic [31:0] addrMem [MAX_DESC];
  logic [1:0]  irqSrc;
  logic        ieLatched;
  logic        inDesc;
  logic [IDX_W-1:0] swIdx;
  logic        isCount, isIrq;
  logic [1:0]  irqSet, irqClr;

  assign inDesc  = ({{(32-ADDR_W){1'b0}}, regAddr} >= 32'(DESC_BASE)) &&
                   ({{(32-ADDR_W){1'b0}}, regAddr} < 32'(DESC_END));
  assign swIdx   = IDX_W'(({{(32-ADDR_W){1'b0}}, regAddr} - 32'(DESC_BASE)) >> 3);
  assign isCount = (regAddr == CNT_OFF);
  assign isIrq   = (regAddr == IRQ_OFF);

  assign curReady = statMem[curIdx][ST_READY];

  // Descriptor storage: software port plus engine write-back (engine wins).
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MAX_DESC; i++) begin
        statMem[i] <= '0;
        addrMem[i] <= '0;
      end
    end else begin
      if (regWrEn && inDesc) begin
        if (regAddr[2]) addrMem[swIdx] <= regWrData;
        else            statMem[swIdx] <= regWrData;
      end
      if (stb.writeBack) begin
        statMem[curIdx] <= {statMem[curIdx][31:ST_READY+1], 1'b0,
                            statMem[curIdx][ST_READY-1:RES_W], doneResult};
      end
    end
  end

  // Frame fields captured at hand-off so later bus writes cannot disturb them.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frmLen    <= '0;
      frmAddr   <= '0;
      frmPad    <= 1'b0;
      frmCrc    <= 1'b0;
      frmWrap   <= 1'b0;
      ieLatched <= 1'b0;
    end else if (stb.load) begin
      frmLen    <= statMem[curIdx][31:16];
      frmAddr   <= addrMem[curIdx];
      frmPad    <= statMem[curIdx][ST_PAD];
      frmCrc    <= statMem[curIdx][ST_CRC];
      frmWrap   <= statMem[curIdx][ST_WRAP];
      ieLatched <= statMem[curIdx][ST_IE];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) descCount <= '0;
    else if (regWrEn && isCount)
      descCount <= (regWrData > 32'(MAX_DESC)) ? CNT_W'(MAX_DESC) : regWrData[CNT_W-1:0];
  end

  always_comb begin
    irqSet = 2'b00;
    if (stb.writeBack && ieLatched) begin
      if (isTxError(doneResult)) irqSet = 2'b10;
      else                       irqSet = 2'b01;
    end
    irqClr = (regWrEn && isIrq) ? regWrData[1:0] : 2'b00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqSrc <= 2'b00;
    else       irqSrc <= (irqSrc & ~irqClr) | irqSet;
  end

  assign irqPending = |irqSrc;

  always_comb begin
    regRdData = '0;
    if (inDesc) begin
      if (regAddr[2]) regRdData = addrMem[swIdx];
      else            regRdData = statMem[swIdx];
    end else if (isCount) begin
      regRdData = 32'(descCount);
    end else if (isIrq) begin
      regRdData = {30'b0, irqSrc};
    end
  end
endmodule

// File: rtl/txr_control.sv
module txr_control
  import txr_pkg::*;
#(
  parameter int MAX_DESC = 128,
  localparam int IDX_W = $clog2(MAX_DESC),
  localparam int CNT_W = $clog2(MAX_DESC + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] descCount,
  input  logic             curReady,
  input  logic             frmWrap,
  input  logic             frmReady,
  input  logic             doneValid,
  output txStrobe_t        stb,
  output logic [IDX_W-1:0] curIdx,
  output logic             frmValid
);
  txState_t state, stateNext;
  logic [IDX_W-1:0] idxNext, idxAdvance;
  logic atLimit;

  assign atLimit    = (CNT_W'(curIdx) + CNT_W'(1)) >= descCount;
  assign idxAdvance = (frmWrap || atLimit) ? '0 : curIdx + IDX_W'(1);

  always_comb begin
    stateNext     = state;
    idxNext       = curIdx;
    stb.load      = 1'b0;
    stb.writeBack = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (descCount != '0) begin
          if (CNT_W'(curIdx) >= descCount) begin
            idxNext = '0;
          end else if (curReady) begin
            stb.load  = 1'b1;
            stateNext = S_OFFER;
          end
        end
      end
      S_OFFER: begin
        if (frmReady) stateNext = S_WAIT;
      end
      S_WAIT: begin
        if (doneValid) begin
          stb.writeBack = 1'b1;
          idxNext       = idxAdvance;
          stateNext     = S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      curIdx <= '0;
    end else begin
      state  <= stateNext;
      curIdx <= idxNext;
    end
  end

  assign frmValid = (state == S_OFFER);
endmodule

// File: rtl/txr_engine.sv
module txr_engine
  import txr_pkg::*;
#(
  parameter int MAX_DESC  = 128,
  parameter int ADDR_W    = 12,
  parameter int DESC_BASE = 'h400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              frmValid,
  input  logic              frmReady,
  output logic [15:0]       frmLen,
  output logic [31:0]       frmAddr,
  output logic              frmPad,
  output logic              frmCrc,
  input  logic              doneValid,
  input  logic [8:0]        doneResult,
  output logic              irqPending
);
  localparam int IDX_W = $clog2(MAX_DESC);
  localparam int CNT_W = $clog2(MAX_DESC + 1);

  txStrobe_t        stb;
  logic [IDX_W-1:0] curIdx;
  logic [CNT_W-1:0] descCount;
  logic             curReady;
  logic             frmWrap;

  txr_control #(.MAX_DESC(MAX_DESC)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .descCount (descCount),
    .curReady  (curReady),
    .frmWrap   (frmWrap),
    .frmReady  (frmReady),
    .doneValid (doneValid),
    .stb       (stb),
    .curIdx    (curIdx),
    .frmValid  (frmValid)
  );

  txr_datapath #(.MAX_DESC(MAX_DESC), .ADDR_W(ADDR_W), .DESC_BASE(DESC_BASE)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .stb        (stb),
    .curIdx     (curIdx),
    .doneResult (doneResult),
    .curReady   (curReady),
    .frmWrap    (frmWrap),
    .descCount  (descCount),
    .frmLen     (frmLen),
    .frmAddr    (frmAddr),
    .frmPad     (frmPad),
    .frmCrc     (frmCrc),
    .irqPending (irqPending)
  );
endmodule

// File: rtl/txr_checker.sv
module txr_checker #(
  parameter int MAX_DESC = 128,
  localparam int IDX_W = $clog2(MAX_DESC),
  localparam int CNT_W = $clog2(MAX_DESC + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             frmValid,
  input logic             frmReady,
  input logic [15:0]      frmLen,
  input logic [31:0]      frmAddr,
  input logic             irqPending,
  input logic [CNT_W-1:0] descCount,
  input logic [IDX_W-1:0] curIdx,
  input logic             stbLoad,
  input logic             stbWriteBack
);
  a_r3_count_cap: assert property (@(posedge clk) disable iff (!rstN)
    descCount <= CNT_W'(MAX_DESC));

  a_r11_load_in_range: assert property (@(posedge clk) disable iff (!rstN)
    stbLoad |-> (CNT_W'(curIdx) < descCount));

  a_r4_offer_hold: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && !frmReady) |=> (frmValid && $stable(frmLen) && $stable(frmAddr)));

  a_r8_irq_after_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPending) |-> $past(stbWriteBack));

  a_r7_no_offer_at_done: assert property (@(posedge clk) disable iff (!rstN)
    stbWriteBack |=> !frmValid);
endmodule

bind txr_engine txr_checker #(.MAX_DESC(MAX_DESC)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .frmValid     (frmValid),
  .frmReady     (frmReady),
  .frmLen       (frmLen),
  .frmAddr      (frmAddr),
  .irqPending   (irqPending),
  .descCount    (descCount),
  .curIdx       (curIdx),
  .stbLoad      (stb.load),
  .stbWriteBack (stb.writeBack)
);

// File: tb/txr_engine_bench.sv
module txr_engine_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        frmValid, frmPad, frmCrc, irqPending;
  logic        frmReady = 1'b0;
  logic [15:0] frmLen;
  logic [31:0] frmAddr;
  logic        doneValid = 1'b0;
  logic [8:0]  doneResult = '0;

  always #4 clk = ~clk;

  txr_engine u_txr_engine (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .frmValid(frmValid),
    .frmReady(frmReady), .frmLen(frmLen), .frmAddr(frmAddr), .frmPad(frmPad),
    .frmCrc(frmCrc), .doneValid(doneValid), .doneResult(doneResult),
    .irqPending(irqPending)
  );

  localparam logic [31:0] RDY = 32'h8000, IEN = 32'h4000, WRP = 32'h2000,
                          PADF = 32'h1000, CRCF = 32'h0800;

  // Behavioural reference model
  logic [31:0] mstat [128];
  logic [31:0] maddr [128];
  int          mcount = 0;
  int          midx = 0;
  logic [1:0]  mirq = 2'b00;

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelWrite(input logic [11:0] a, input logic [31:0] d);
    if (a == 12'h000) begin
      mcount = (d > 128) ? 128 : int'(d);
      if (mcount != 0 && midx >= mcount) midx = 0;
    end else if (a == 12'h004) begin
      mirq = mirq & ~d[1:0];
    end else if (a >= 12'h400 && a < 12'h800) begin
      if (a[2]) maddr[(a - 12'h400) >> 3] = d;
      else      mstat[(a - 12'h400) >> 3] = d;
    end
  endtask

  task automatic modelDone(input logic [8:0] res);
    logic [31:0] s;
    bit err;
    s = mstat[midx];
    err = res[0] | res[2] | res[3] | res[8];
    mstat[midx] = {s[31:16], 1'b0, s[14:9], res};
    if (s[14]) mirq = mirq | (err ? 2'b10 : 2'b01);
    if (s[13] || midx + 1 >= mcount) midx = 0;
    else midx = midx + 1;
  endtask

  task automatic wrReg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk);
    modelWrite(a, d);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic setDesc(input int i, input logic [31:0] st, input logic [31:0] ad);
    wrReg(12'(12'h404 + 8 * i), ad);
    wrReg(12'(12'h400 + 8 * i), st);
  endtask

  task automatic quiet(input int n, input string tag);
    bit seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (frmValid) seen = 1;
    end
    check(!seen, tag, 64'(seen), 64'd0);
  endtask

  task automatic acceptFrame(input string tag);
    @(negedge clk);
    for (int k = 0; k < 40; k++) begin
      if (frmValid) break;
      @(negedge clk);
    end
    check(frmValid, tag, 64'(frmValid), 64'd1);
    check({frmLen, frmAddr, frmPad, frmCrc} ==
          {mstat[midx][31:16], maddr[midx], mstat[midx][12], mstat[midx][11]},
          tag, {frmLen, frmAddr, frmPad, frmCrc},
          {mstat[midx][31:16], maddr[midx], mstat[midx][12], mstat[midx][11]});
    frmReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    frmReady = 1'b0;
    check(!frmValid, "R4", 64'(frmValid), 64'd0);
  endtask

  task automatic completeFrame(input logic [8:0] res);
    @(negedge clk);
    doneValid = 1'b1; doneResult = res;
    @(posedge clk);
    modelDone(res);
    @(negedge clk);
    doneValid = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(irqPending == (mirq != 2'b00), "R8", 64'(irqPending), 64'(mirq != 2'b00));
      if (frmValid) begin
        check(mstat[midx][15] && {frmLen, frmAddr, frmPad, frmCrc} ==
              {mstat[midx][31:16], maddr[midx], mstat[midx][12], mstat[midx][11]},
              "R4", {frmLen, frmAddr, frmPad, frmCrc},
              {mstat[midx][31:16], maddr[midx], mstat[midx][12], mstat[midx][11]});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish();
    end
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 128; i++) begin mstat[i] = '0; maddr[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check(!frmValid && !irqPending, "R1", {frmValid, irqPending}, 0);
    rdReg(12'h000, d); check(d == 0, "R1", d, 0);
    rdReg(12'h004, d); check(d == 0, "R1", d, 0);
    rdReg(12'h400, d); check(d == 0, "R1", d, 0);
    rdReg(12'h7fc, d); check(d == 0, "R1", d, 0);

    // R3 count saturation
    wrReg(12'h000, 32'd200);  rdReg(12'h000, d); check(d == 128, "R3", d, 128);
    wrReg(12'h000, 32'd129);  rdReg(12'h000, d); check(d == 128, "R3", d, 128);
    wrReg(12'h000, 32'h80);   rdReg(12'h000, d); check(d == 128, "R3", d, 128);
    wrReg(12'h000, 32'd5);    rdReg(12'h000, d); check(d == 5, "R3", d, 5);
    wrReg(12'h000, 32'd0);    rdReg(12'h000, d); check(d == 0, "R11", d, 0);

    // R2 descriptor addressing
    setDesc(5, 32'h0123_4800, 32'hdead_beef);
    rdReg(12'h428, d); check(d == 32'h0123_4800, "R2", d, 32'h0123_4800);
    rdReg(12'h42c, d); check(d == 32'hdead_beef, "R2", d, 32'hdead_beef);

    // R11 count zero: nothing offered
    setDesc(0, {16'd100, 16'h0} | RDY | IEN | CRCF, 32'h1000_0000);
    quiet(20, "R11");
    wrReg(12'h000, 32'd3);
    acceptFrame("R4");
    completeFrame(9'h032);  // deferred + retry count 3: success
    rdReg(12'h400, d); check(d == {16'd100, 16'h4832}, "R6", d, {16'd100, 16'h4832});
    rdReg(12'h004, d); check(d == 32'd1, "R9", d, 1);
    wrReg(12'h004, 32'd1);
    rdReg(12'h004, d); check(d == 32'd0, "R9", d, 0);

    // R5 ownership wait: index 1 not ready, index 2 ready
    setDesc(2, {16'd40, 16'h0} | RDY | PADF, 32'h2000_0000);
    quiet(20, "R5");
    setDesc(1, {16'd70, 16'h0} | RDY | IEN, 32'h3000_0000);
    acceptFrame("R5");
    completeFrame(9'h100);  // underrun: error
    rdReg(12'h004, d); check(d == 32'd2, "R8", d, 2);
    acceptFrame("R4");      // index 2, pad set, no interrupt request
    completeFrame(9'h000);
    rdReg(12'h004, d); check(d == 32'd2, "R8", d, 2);
    check(midx == 0, "R7", 64'(midx), 0);
    wrReg(12'h004, 32'd3);
    rdReg(12'h004, d); check(d == 32'd0, "R9", d, 0);

    // R7 wrap bit returns to index 0
    setDesc(1, {16'd80, 16'h0} | RDY, 32'h4000_0000);
    setDesc(0, {16'd90, 16'h0} | RDY | WRP | IEN, 32'h5000_0000);
    acceptFrame("R7");
    completeFrame(9'h004);  // late collision: error
    rdReg(12'h004, d); check(d == 32'd2, "R8", d, 2);
    quiet(20, "R7");        // engine waits at 0 although 1 is ready
    wrReg(12'h004, 32'd2);
    wrReg(12'h400, {16'd91, 16'h0} | RDY);
    acceptFrame("R7");
    completeFrame(9'h000);
    acceptFrame("R7");      // index 1
    completeFrame(9'h000);
    check(midx == 2, "R7", 64'(midx), 2);

    // R10 rewrite while in flight
    setDesc(2, {16'd200, 16'h0} | RDY | IEN, 32'hA000_0000);
    acceptFrame("R10");
    setDesc(2, {16'd300, 16'h0} | RDY | IEN, 32'hB000_0000);
    check(frmLen == 16'd200 && frmAddr == 32'hA000_0000, "R10",
          {frmLen, frmAddr}, {16'd200, 32'hA000_0000});
    completeFrame(9'h008);  // retry limit: error
    rdReg(12'h410, d); check(d == {16'd300, 16'h4008}, "R10", d, {16'd300, 16'h4008});
    rdReg(12'h414, d); check(d == 32'hB000_0000, "R10", d, 32'hB000_0000);
    wrReg(12'h004, 32'd3);

    // R11 lowering the count below the index restarts at 0
    setDesc(0, {16'd60, 16'h0} | RDY, 32'hC000_0000);
    setDesc(1, {16'd61, 16'h0} | RDY, 32'hC100_0000);
    acceptFrame("R11"); completeFrame(9'h000);
    acceptFrame("R11"); completeFrame(9'h000);
    check(midx == 2, "R11", 64'(midx), 2);
    wrReg(12'h000, 32'd2);
    setDesc(0, {16'd62, 16'h0} | RDY | IEN, 32'hC200_0000);
    acceptFrame("R11");
    check(frmAddr == 32'hC200_0000, "R11", frmAddr, 32'hC200_0000);
    completeFrame(9'h001);  // carrier lost: error
    rdReg(12'h004, d); check(d == 32'd2, "R8", d, 2);

    repeat (5) @(negedge clk);
    finish();
  end
endmodule